// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional

This block sits next to a shared memory and keeps track of address reservations made by several requesting contexts, where a context is the pair of a CPU number and a thread number. A load-reserved request records a reservation on a granule of the address space for its context. A store-conditional request from the same context succeeds only if that reservation is still in place. Any write to a reserved granule, whether plain or conditional, cancels every reservation on that granule.

One request is presented per clock cycle. It carries an operation code, the context and a byte address. The address is reduced to a granule number by dropping its low `GRAN_LOG2` bits. The lookup and the table update both complete in the cycle of the request. The verdict comes out of registers on the next cycle: a memory write-enable, the store-conditional result bit and an overflow flag for a reservation that found no free table slot. The memory array itself is not part of the block.

Top module: `rsv_monitor`

## Requirements
- R1: Two addresses whose bits above bit `GRAN_LOG2-1` are equal fall in the same granule. Every comparison and every recorded reservation uses only the granule number.
- R2: A context owns at most one reservation. A load-reserved from a context that already owns one moves that reservation to the new granule, and the old granule is no longer reserved for it. No extra slot is used, so this never raises overflow.
- R3: A load-reserved from a context with no reservation takes a free slot. If all `ENTRIES` slots are in use, `rsp_overflow` is 1 on the next cycle and the table is unchanged.
- R4: A plain store gives `rsp_wr_en`=1 and `rsp_sc_ok`=0 on the next cycle.
- R5: A store-conditional succeeds only when one table entry matches both the requesting context (CPU number and thread number together) and the request's granule. On success `rsp_sc_ok`=1, otherwise 0, and `rsp_wr_en` equals `rsp_sc_ok`.
- R6: Every write removes all entries on the written granule, whichever context owns them. This covers a plain store and a store-conditional, whether the conditional succeeds or fails. Several entries can be removed in one cycle.
- R7: A store-conditional from a context whose reservation is on a different granule fails, and that context's reservation stays valid.
- R8: Operation codes on `req_op` are 0 idle, 1 load-reserved, 2 store and 3 store-conditional. Outputs are registered and reflect the request of the previous cycle. After an idle request or a load-reserved, `rsp_wr_en` and `rsp_sc_ok` are 0, and after an idle request `rsp_overflow` is also 0.
- R9: A synchronous active-high `rst` removes all reservations and clears all three outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_op | input | 2 | Operation code (0 idle, 1 load-reserved, 2 store, 3 store-conditional) |
| req_cpu | input | CPU_W | CPU number of the requesting context |
| req_thread | input | THR_W | Thread number of the requesting context |
| req_addr | input | ADDR_W | Byte address of the request |
| rsp_wr_en | output | 1 | Memory write permitted for the previous request |
| rsp_sc_ok | output | 1 | Store-conditional result of the previous request (1 success, 0 failure) |
| rsp_overflow | output | 1 | Previous load-reserved found no free slot |

## Verification
The bench builds the block with `ENTRIES`=4, two CPU bits and one thread bit. Eight contexts then compete for four slots, so the table-full path and its overflow flag are reached often, in both random and directed traffic. With 12-bit addresses, 8-byte granules and random traffic spread over only six granules, shared reservations are frequent. This exercises the multi-entry clear on one write, store-conditional success, and the moving of a reservation that is already held.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    typedef enum logic [1:0] {
        OP_IDLE       = 2'd0,
        OP_LOAD_RSV   = 2'd1,
        OP_STORE      = 2'd2,
        OP_STORE_COND = 2'd3
    } rsv_op_e;

    typedef struct packed {
        logic wr_en;
        logic sc_ok;
        logic overflow;
    } rsv_rsp_t;

    localparam rsv_rsp_t RSP_NONE = '{wr_en: 1'b0, sc_ok: 1'b0, overflow: 1'b0};

    function automatic logic op_writes(rsv_op_e op);
        return (op == OP_STORE) || (op == OP_STORE_COND);
    endfunction

endpackage

// File: rtl/rsv_slot.sv
module rsv_slot #(
    parameter int CTX_W  = 3,
    parameter int GRAN_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic [GRAN_W-1:0] req_gran,
    output logic              vld,
    output logic [GRAN_W-1:0] gran,
    output logic              ctx_hit,
    output logic              gran_hit
);
    logic [CTX_W-1:0] owner;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld   <= 1'b0;
            owner <= '0;
            gran  <= '0;
        end else if (set_en) begin
            vld   <= 1'b1;
            owner <= req_ctx;
            gran  <= req_gran;
        end else if (clr_en) begin
            vld   <= 1'b0;
        end
    end

    assign ctx_hit  = vld && (owner == req_ctx);
    assign gran_hit = vld && (gran == req_gran);
endmodule

// File: rtl/rsv_pick_free.sv
module rsv_pick_free #(
    parameter int ENTRIES = 8
) (
    input  logic [ENTRIES-1:0] vld,
    output logic [ENTRIES-1:0] free_oh,
    output logic               any_free
);
    always_comb begin
        free_oh = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                free_oh    = '0;
                free_oh[i] = 1'b1;
            end
        end
    end

    assign any_free = ~&vld;
endmodule

// File: rtl/rsv_decide.sv
module rsv_decide
    import rsv_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  rsv_op_e            op,
    input  logic [ENTRIES-1:0] ctx_hit,
    input  logic [ENTRIES-1:0] gran_hit,
    input  logic [ENTRIES-1:0] free_oh,
    input  logic               any_free,
    output logic [ENTRIES-1:0] set_vec,
    output logic [ENTRIES-1:0] clr_vec,
    output rsv_rsp_t           rsp_next
);
    logic own_hit;
    logic has_ctx;

    assign own_hit = |(ctx_hit & gran_hit);
    assign has_ctx = |ctx_hit;

    always_comb begin
        set_vec  = '0;
        clr_vec  = '0;
        rsp_next = RSP_NONE;
        if (op == OP_LOAD_RSV) begin
            if (has_ctx) begin
                set_vec = ctx_hit;
            end else if (any_free) begin
                set_vec = free_oh;
            end else begin
                rsp_next.overflow = 1'b1;
            end
        end else if (op_writes(op)) begin
            clr_vec        = gran_hit;
            rsp_next.sc_ok = (op == OP_STORE_COND) && own_hit;
            rsp_next.wr_en = (op == OP_STORE) || rsp_next.sc_ok;
        end
    end
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
    import rsv_pkg::*;
#(
    parameter int ENTRIES   = 8,
    parameter int CPU_W     = 2,
    parameter int THR_W     = 1,
    parameter int ADDR_W    = 16,
    parameter int GRAN_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        req_op,
    input  logic [CPU_W-1:0]  req_cpu,
    input  logic [THR_W-1:0]  req_thread,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_wr_en,
    output logic              rsp_sc_ok,
    output logic              rsp_overflow
);
    localparam int CTX_W  = CPU_W + THR_W;
    localparam int GRAN_W = ADDR_W - GRAN_LOG2;

    rsv_op_e                         op;
    logic [CTX_W-1:0]                req_ctx;
    logic [GRAN_W-1:0]               req_gran;
    logic [ENTRIES-1:0]              ent_vld;
    logic [ENTRIES-1:0][GRAN_W-1:0]  ent_gran;
    logic [ENTRIES-1:0]              ctx_hit;
    logic [ENTRIES-1:0]              gran_hit;
    logic [ENTRIES-1:0]              free_oh;
    logic                            any_free;
    logic [ENTRIES-1:0]              set_vec;
    logic [ENTRIES-1:0]              clr_vec;
    rsv_rsp_t                        rsp_next;
    rsv_rsp_t                        rsp_q;

    assign op       = rsv_op_e'(req_op);
    assign req_ctx  = {req_cpu, req_thread};
    assign req_gran = req_addr[ADDR_W-1:GRAN_LOG2];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        rsv_slot #(
            .CTX_W  (CTX_W),
            .GRAN_W (GRAN_W)
        ) u_slot (
            .clk      (clk),
            .rst      (rst),
            .set_en   (set_vec[g]),
            .clr_en   (clr_vec[g]),
            .req_ctx  (req_ctx),
            .req_gran (req_gran),
            .vld      (ent_vld[g]),
            .gran     (ent_gran[g]),
            .ctx_hit  (ctx_hit[g]),
            .gran_hit (gran_hit[g])
        );
    end

    rsv_pick_free #(.ENTRIES(ENTRIES)) u_pick (
        .vld      (ent_vld),
        .free_oh  (free_oh),
        .any_free (any_free)
    );

    rsv_decide #(.ENTRIES(ENTRIES)) u_decide (
        .op       (op),
        .ctx_hit  (ctx_hit),
        .gran_hit (gran_hit),
        .free_oh  (free_oh),
        .any_free (any_free),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .rsp_next (rsp_next)
    );

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= RSP_NONE;
        else     rsp_q <= rsp_next;
    end

    assign rsp_wr_en    = rsp_q.wr_en;
    assign rsp_sc_ok    = rsp_q.sc_ok;
    assign rsp_overflow = rsp_q.overflow;
endmodule

// File: rtl/rsv_monitor_chk.sv
module rsv_monitor_chk #(
    parameter int ENTRIES = 8,
    parameter int GRAN_W  = 13
) (
    input logic                           clk,
    input logic                           rst,
    input logic [1:0]                     req_op,
    input logic [GRAN_W-1:0]              req_gran,
    input logic [ENTRIES-1:0]             ent_vld,
    input logic [ENTRIES-1:0][GRAN_W-1:0] ent_gran,
    input logic [ENTRIES-1:0]             ctx_hit,
    input logic                           rsp_wr_en,
    input logic                           rsp_sc_ok,
    input logic                           rsp_overflow
);
    logic              last_write;
    logic [GRAN_W-1:0] last_gran;
    logic [ENTRIES-1:0] stale;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_write <= 1'b0;
            last_gran  <= '0;
        end else begin
            last_write <= req_op[1];
            last_gran  <= req_gran;
        end
    end

    always_comb begin
        for (int i = 0; i < ENTRIES; i++)
            stale[i] = ent_vld[i] && (ent_gran[i] == last_gran);
    end

    // R2: never two entries for the requesting context
    a_r2_one_per_ctx: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ctx_hit));

    // R4: plain store always writes
    a_r4_store_writes: assert property (@(posedge clk) disable iff (rst)
        (req_op == 2'd2) |=> (rsp_wr_en && !rsp_sc_ok));

    // R5: conditional write enable follows its result
    a_r5_sc_wr_match: assert property (@(posedge clk) disable iff (rst)
        (req_op == 2'd3) |=> (rsp_wr_en == rsp_sc_ok));

    // R6: no entry survives on a granule just written
    a_r6_granule_cleared: assert property (@(posedge clk) disable iff (rst)
        last_write |-> (stale == '0));

    // R8: load-reserved never writes, overflow only after load-reserved
    a_r8_lr_no_write: assert property (@(posedge clk) disable iff (rst)
        (req_op == 2'd1) |=> (!rsp_wr_en && !rsp_sc_ok));
    a_r3_overflow_src: assert property (@(posedge clk) disable iff (rst)
        (req_op != 2'd1) |=> !rsp_overflow);

    // R9: reset empties the table and the outputs
    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (ent_vld == '0 && !rsp_wr_en && !rsp_sc_ok && !rsp_overflow));
endmodule

bind rsv_monitor rsv_monitor_chk #(
    .ENTRIES (ENTRIES),
    .GRAN_W  (GRAN_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_op       (req_op),
    .req_gran     (req_gran),
    .ent_vld      (ent_vld),
    .ent_gran     (ent_gran),
    .ctx_hit      (ctx_hit),
    .rsp_wr_en    (rsp_wr_en),
    .rsp_sc_ok    (rsp_sc_ok),
    .rsp_overflow (rsp_overflow)
);

// File: tb/rsv_monitor_bench.sv
module rsv_monitor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES    = 4;
    localparam int CPU_W      = 2;
    localparam int THR_W      = 1;
    localparam int ADDR_W     = 12;
    localparam int GRAN_LOG2  = 3;
    localparam int CTX_W      = CPU_W + THR_W;
    localparam int GRAN_W     = ADDR_W - GRAN_LOG2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        req_op = 2'd0;
    logic [CPU_W-1:0]  req_cpu = '0;
    logic [THR_W-1:0]  req_thread = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              rsp_wr_en, rsp_sc_ok, rsp_overflow;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic              m_vld  [ENTRIES];
    logic [CTX_W-1:0]  m_ctx  [ENTRIES];
    logic [GRAN_W-1:0] m_gran [ENTRIES];

    always #(CLK_PERIOD/2) clk = ~clk;

    rsv_monitor #(
        .ENTRIES(ENTRIES), .CPU_W(CPU_W), .THR_W(THR_W),
        .ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)
    ) u_rsv_monitor (
        .clk(clk), .rst(rst), .req_op(req_op), .req_cpu(req_cpu),
        .req_thread(req_thread), .req_addr(req_addr),
        .rsp_wr_en(rsp_wr_en), .rsp_sc_ok(rsp_sc_ok), .rsp_overflow(rsp_overflow)
    );

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {wr,sc,ovf} actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < ENTRIES; i++) m_vld[i] = 1'b0;
    endtask

    // Reference behaviour from the requirements
    task automatic model_step(input logic [1:0] op, input logic [CTX_W-1:0] ctx,
                              input logic [GRAN_W-1:0] gr, output logic [2:0] exp);
        bit found;
        bit own;
        exp = 3'b000;
        if (op == 2'd1) begin
            found = 0;
            for (int i = 0; i < ENTRIES; i++)
                if (m_vld[i] && m_ctx[i] == ctx) begin m_gran[i] = gr; found = 1; end
            if (!found) begin
                for (int i = 0; i < ENTRIES; i++)
                    if (!found && !m_vld[i]) begin
                        m_vld[i] = 1'b1; m_ctx[i] = ctx; m_gran[i] = gr; found = 1;
                    end
                if (!found) exp = 3'b001;
            end
        end else if (op[1]) begin
            own = 0;
            for (int i = 0; i < ENTRIES; i++)
                if (m_vld[i] && m_gran[i] == gr) begin
                    if (m_ctx[i] == ctx) own = 1;
                    m_vld[i] = 1'b0;
                end
            if (op == 2'd2) exp = 3'b100;
            else            exp = own ? 3'b110 : 3'b000;
        end
    endtask

    task automatic do_op(input logic [1:0] op, input logic [CTX_W-1:0] ctx,
                         input logic [ADDR_W-1:0] addr, input string tag,
                         input bit fixed, input logic [2:0] fexp);
        logic [2:0] exp;
        @(negedge clk);
        req_op = op;
        {req_cpu, req_thread} = ctx;
        req_addr = addr;
        model_step(op, ctx, addr[ADDR_W-1:GRAN_LOG2], exp);
        @(posedge clk);
        #1;
        check(tag, {rsp_wr_en, rsp_sc_ok, rsp_overflow}, exp);
        if (fixed) check({tag, " (directed)"}, {rsp_wr_en, rsp_sc_ok, rsp_overflow}, fexp);
        req_op = 2'd0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_op = 2'd0;
        @(posedge clk);
        #1;
        model_clear();
        check("R9 reset outputs", {rsp_wr_en, rsp_sc_ok, rsp_overflow}, 3'b000);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_clear();
        repeat (2) @(posedge clk);
        do_reset();

        // R1, R5: same granule via different byte offsets
        do_op(2'd1, 3'd1, 12'h100, "R1 lr", 1, 3'b000);
        do_op(2'd3, 3'd1, 12'h107, "R1 R5 sc same granule", 1, 3'b110);
        // R6: own successful SC consumed the reservation
        do_op(2'd3, 3'd1, 12'h100, "R6 sc after consume", 1, 3'b000);
        // R1: adjacent granule is distinct
        do_op(2'd1, 3'd1, 12'h100, "R1 lr", 1, 3'b000);
        do_op(2'd3, 3'd1, 12'h108, "R1 sc next granule", 1, 3'b000);
        // R2: reservation moves
        do_op(2'd1, 3'd2, 12'h200, "R2 lr first", 1, 3'b000);
        do_op(2'd1, 3'd2, 12'h300, "R2 lr move", 1, 3'b000);
        do_op(2'd3, 3'd2, 12'h200, "R2 sc old granule", 1, 3'b000);
        do_op(2'd3, 3'd2, 12'h300, "R2 sc new granule", 1, 3'b110);
        // R4, R6: plain store clears two owners
        do_op(2'd1, 3'd3, 12'h400, "R6 lr a", 1, 3'b000);
        do_op(2'd1, 3'd4, 12'h404, "R6 lr b", 1, 3'b000);
        do_op(2'd2, 3'd5, 12'h406, "R4 store", 1, 3'b100);
        do_op(2'd3, 3'd3, 12'h400, "R6 sc a cleared", 1, 3'b000);
        do_op(2'd3, 3'd4, 12'h400, "R6 sc b cleared", 1, 3'b000);
        // R7 and R6 with failed SC
        do_op(2'd1, 3'd3, 12'h500, "R7 lr a", 1, 3'b000);
        do_op(2'd1, 3'd4, 12'h600, "R7 lr b", 1, 3'b000);
        do_op(2'd3, 3'd4, 12'h500, "R7 sc wrong granule", 1, 3'b000);
        do_op(2'd3, 3'd4, 12'h600, "R7 own kept", 1, 3'b110);
        do_op(2'd3, 3'd3, 12'h500, "R6 failed sc cleared", 1, 3'b000);
        // R8: idle
        do_op(2'd0, 3'd3, 12'h500, "R8 idle", 1, 3'b000);
        // R9: reset removes reservations
        do_op(2'd1, 3'd6, 12'h700, "R9 lr", 1, 3'b000);
        do_reset();
        do_op(2'd3, 3'd6, 12'h700, "R9 sc after reset", 1, 3'b000);
        // R3: fill and overflow
        for (int c = 0; c < ENTRIES; c++)
            do_op(2'd1, CTX_W'(c), ADDR_W'(12'h800 + c * 16), "R3 fill", 1, 3'b000);
        do_op(2'd1, 3'd7, 12'h900, "R3 overflow", 1, 3'b001);
        do_op(2'd1, 3'd1, 12'h910, "R2 full no overflow", 1, 3'b000);
        do_op(2'd3, 3'd7, 12'h900, "R3 overflowed lr not recorded", 1, 3'b000);
        do_op(2'd2, 3'd7, 12'h800, "R4 store frees slot", 1, 3'b100);
        do_op(2'd1, 3'd7, 12'h900, "R3 alloc freed slot", 1, 3'b000);
        do_op(2'd3, 3'd7, 12'h900, "R3 R5 sc after alloc", 1, 3'b110);

        // Random traffic checked against the model
        for (int n = 0; n < 800; n++) begin
            int sel;
            logic [1:0] op;
            string tag;
            sel = $urandom_range(9);
            if (sel == 0)      begin op = 2'd0; tag = "R8 rand idle"; end
            else if (sel < 5)  begin op = 2'd1; tag = "R3 rand lr"; end
            else if (sel < 7)  begin op = 2'd2; tag = "R4 rand store"; end
            else               begin op = 2'd3; tag = "R5 rand sc"; end
            do_op(op, CTX_W'($urandom_range(7)),
                  ADDR_W'(12'h300 + $urandom_range(5) * 8 + $urandom_range(7)),
                  tag, 0, 3'b000);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule